// File: doc/BRIEF.md
# Parallel Port Forward Byte Transmitter

This block is the host end of a classic printer-style parallel link, carrying bytes from host to peripheral only. A byte offered on a valid/ready input is captured and driven onto the eight parallel data lines. After a setup interval, the block checks the peripheral's busy and error lines. Once both are clear, it drives an active-low strobe of a programmed width. It then keeps the byte on the lines for a hold interval before it takes the next byte.

A short cycle-counted sequencer does the work that software would otherwise do by writing registers. The order of one transfer is fixed: load the data, wait out the setup time, check the status, pull the strobe low, release the strobe, hold. Error reports from the peripheral latch into a sticky flag that only a clear input removes. A peripheral that stays busy or faulted for too long makes the block abandon the byte and report a timeout. Four configuration inputs set the setup, strobe, hold and timeout lengths in clock cycles. Every length has a minimum of one cycle, so a programmed value of 0 behaves as 1.

Top module: `pp_fwd_tx`

## Requirements
- R1: While reset is held, and right after it, in_ready is 1, strobe_n is 1, pd_out is 0, err_flag is 0 and timeout_o is 0.
- R2: A byte is accepted on a clock edge where in_valid and in_ready are both 1. From that edge on, pd_out carries the byte and in_ready is 0. pd_out does not change while in_ready stays 0, whatever in_valid and in_data do.
- R3: If the peripheral is idle and error-free, strobe_n falls exactly Ls+1 clock edges after the accepting edge, where Ls = max(setup_cyc,1).
- R4: strobe_n stays high while busy_in, err_in or err_flag is 1. It falls on the first edge after a status check cycle in which all three are 0.
- R5: strobe_n stays low for exactly max(strobe_cyc,1) cycles.
- R6: After strobe_n rises, pd_out is held and in_ready stays 0 for exactly max(hold_cyc,1) cycles. in_ready is never 1 while strobe_n is 0.
- R7: If the status check is blocked for max(timeout_cyc,1) consecutive cycles, the block returns to idle without any strobe. timeout_o is 1 for exactly one cycle, and that cycle is the first one in which in_ready is 1 again.
- R8: err_in being 1 at a clock edge sets err_flag from that edge on. err_flag stays set until an edge where clr_err is 1 and err_in is 0.
- R9: If err_in and clr_err are both 1 at the same edge, err_flag is set.
- R10: busy_in or err_in rising while the strobe is low does not shorten or cut off the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte offered on in_data |
| in_data | input | DATA_W | Byte to send |
| in_ready | output | 1 | Block is idle and will take a byte |
| pd_out | output | DATA_W | Parallel data lines toward the peripheral |
| strobe_n | output | 1 | Active-low data strobe |
| busy_in | input | 1 | Peripheral busy, active high |
| err_in | input | 1 | Peripheral error report, active high |
| clr_err | input | 1 | Clears the sticky error flag |
| err_flag | output | 1 | Sticky error flag |
| timeout_o | output | 1 | One-cycle pulse when a transfer is abandoned |
| setup_cyc | input | CNT_W | Data setup length in cycles |
| strobe_cyc | input | CNT_W | Strobe low length in cycles |
| hold_cyc | input | CNT_W | Data hold length in cycles |
| timeout_cyc | input | TO_W | Blocked status-check limit in cycles |

## Verification
The checker module tests the rules that hold on every cycle:
- pd_out stays still while the block is busy.
- in_ready drops after an accept.
- strobe_n never falls unless the status was clear on the cycle before.
- strobe_n is low for exactly the programmed width.
- in_ready and the strobe are never active together.
- timeout_o is a single pulse with no strobe.
- err_flag sets and stays set.

The bench's scenarios are the only place that shows the exact cycle counts from accept to strobe and from strobe release to ready. They also show the full length of a timeout and the release of a blocked transfer when the busy line drops or the error flag is cleared. They show that the strobe keeps its width when busy rises in the middle of it.

// File: rtl/pp_fwd_pkg.sv
package pp_fwd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_CHECK  = 3'd2,
    ST_STROBE = 3'd3,
    ST_HOLD   = 3'd4
  } pp_state_e;

  // A programmed length of zero counts as one cycle.
  function automatic logic [31:0] eff_len(input logic [31:0] cfg);
    return (cfg == 32'd0) ? 32'd1 : cfg;
  endfunction

  // True on the final cycle of a stage of eff_len(cfg) cycles.
  function automatic logic stage_last(input logic [31:0] cnt, input logic [31:0] cfg);
    return cnt == (eff_len(cfg) - 32'd1);
  endfunction

endpackage

// File: rtl/pp_fwd_status.sv
module pp_fwd_status (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_in,
  input  logic err_in,
  input  logic clr_err,
  output logic err_flag,
  output logic blocked
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      err_flag <= 1'b0;
    else if (err_in)
      err_flag <= 1'b1;
    else if (clr_err)
      err_flag <= 1'b0;
  end

  assign blocked = busy_in | err_in | err_flag;

endmodule

// File: rtl/pp_fwd_datareg.sv
module pp_fwd_datareg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dout <= '0;
    else if (load)
      dout <= din;
  end

endmodule

// File: rtl/pp_fwd_seq.sv
module pp_fwd_seq
  import pp_fwd_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [CNT_W-1:0] setup_cyc,
  input  logic [CNT_W-1:0] strobe_cyc,
  input  logic [CNT_W-1:0] hold_cyc,
  input  logic [TO_W-1:0]  timeout_cyc,
  input  logic             blocked,
  output pp_state_e        state,
  output logic             accept_ev,
  output logic             strobe_start_ev,
  output logic             strobe_end_ev,
  output logic             hold_done_ev,
  output logic             abort_ev,
  output logic             in_ready,
  output logic             strobe_n,
  output logic             timeout_o
);

  localparam int CW = (CNT_W > TO_W) ? CNT_W : TO_W;

  pp_state_e       nxt;
  logic [CW-1:0]   cnt, cnt_n;

  always_comb begin
    nxt             = state;
    cnt_n           = cnt + 1'b1;
    accept_ev       = 1'b0;
    strobe_start_ev = 1'b0;
    strobe_end_ev   = 1'b0;
    hold_done_ev    = 1'b0;
    abort_ev        = 1'b0;
    case (state)
      ST_IDLE: begin
        cnt_n = '0;
        if (in_valid) begin
          nxt       = ST_SETUP;
          accept_ev = 1'b1;
        end
      end
      ST_SETUP: begin
        if (stage_last(32'(cnt), 32'(setup_cyc))) begin
          nxt   = ST_CHECK;
          cnt_n = '0;
        end
      end
      ST_CHECK: begin
        if (!blocked) begin
          nxt             = ST_STROBE;
          cnt_n           = '0;
          strobe_start_ev = 1'b1;
        end else if (stage_last(32'(cnt), 32'(timeout_cyc))) begin
          nxt      = ST_IDLE;
          cnt_n    = '0;
          abort_ev = 1'b1;
        end
      end
      ST_STROBE: begin
        if (stage_last(32'(cnt), 32'(strobe_cyc))) begin
          nxt           = ST_HOLD;
          cnt_n         = '0;
          strobe_end_ev = 1'b1;
        end
      end
      ST_HOLD: begin
        if (stage_last(32'(cnt), 32'(hold_cyc))) begin
          nxt          = ST_IDLE;
          cnt_n        = '0;
          hold_done_ev = 1'b1;
        end
      end
      default: begin
        nxt   = ST_IDLE;
        cnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      timeout_o <= 1'b0;
    end else begin
      state     <= nxt;
      cnt       <= cnt_n;
      timeout_o <= abort_ev;
    end
  end

  assign in_ready = (state == ST_IDLE);
  assign strobe_n = (state != ST_STROBE);

endmodule

// File: rtl/pp_fwd_tx.sv
module pp_fwd_tx
  import pp_fwd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int TO_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic [DATA_W-1:0] pd_out,
  output logic              strobe_n,
  input  logic              busy_in,
  input  logic              err_in,
  input  logic              clr_err,
  output logic              err_flag,
  output logic              timeout_o,
  input  logic [CNT_W-1:0]  setup_cyc,
  input  logic [CNT_W-1:0]  strobe_cyc,
  input  logic [CNT_W-1:0]  hold_cyc,
  input  logic [TO_W-1:0]   timeout_cyc
);

  pp_state_e state;
  logic      blocked;
  logic      accept_ev, strobe_start_ev, strobe_end_ev, hold_done_ev, abort_ev;

  pp_fwd_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_in  (busy_in),
    .err_in   (err_in),
    .clr_err  (clr_err),
    .err_flag (err_flag),
    .blocked  (blocked)
  );

  pp_fwd_datareg #(.DATA_W(DATA_W)) u_data (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept_ev),
    .din   (in_data),
    .dout  (pd_out)
  );

  pp_fwd_seq #(.CNT_W(CNT_W), .TO_W(TO_W)) u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .setup_cyc       (setup_cyc),
    .strobe_cyc      (strobe_cyc),
    .hold_cyc        (hold_cyc),
    .timeout_cyc     (timeout_cyc),
    .blocked         (blocked),
    .state           (state),
    .accept_ev       (accept_ev),
    .strobe_start_ev (strobe_start_ev),
    .strobe_end_ev   (strobe_end_ev),
    .hold_done_ev    (hold_done_ev),
    .abort_ev        (abort_ev),
    .in_ready        (in_ready),
    .strobe_n        (strobe_n),
    .timeout_o       (timeout_o)
  );

endmodule

// File: rtl/pp_fwd_tx_chk.sv
module pp_fwd_tx_chk
  import pp_fwd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] pd_out,
  input logic              strobe_n,
  input logic              busy_in,
  input logic              err_in,
  input logic              clr_err,
  input logic              err_flag,
  input logic              timeout_o,
  input logic [CNT_W-1:0]  strobe_cyc,
  input logic              strobe_start_ev,
  input logic              strobe_end_ev,
  input logic              abort_ev
);

  logic [31:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_cnt <= '0;
    else if (strobe_n) low_cnt <= '0;
    else               low_cnt <= low_cnt + 32'd1;
  end

  assert_data_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !$past(in_ready)) |-> $stable(pd_out));

  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_strobe_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_n) |-> $past(!busy_in && !err_in && !err_flag));

  assert_strobe_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_start_ev |=> !strobe_n);

  assert_strobe_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_n) |-> (low_cnt == eff_len(32'(strobe_cyc))));

  assert_strobe_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_end_ev |=> strobe_n);

  assert_no_ready_in_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |-> !in_ready);

  assert_ready_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> (strobe_n && $past(strobe_n)));

  assert_abort_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (timeout_o && in_ready));

  assert_timeout_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  assert_timeout_nostrobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (strobe_n && $past(strobe_n)));

  assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_in |=> err_flag);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr_err) |=> err_flag);

endmodule

bind pp_fwd_tx pp_fwd_tx_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .in_ready        (in_ready),
  .pd_out          (pd_out),
  .strobe_n        (strobe_n),
  .busy_in         (busy_in),
  .err_in          (err_in),
  .clr_err         (clr_err),
  .err_flag        (err_flag),
  .timeout_o       (timeout_o),
  .strobe_cyc      (strobe_cyc),
  .strobe_start_ev (strobe_start_ev),
  .strobe_end_ev   (strobe_end_ev),
  .abort_ev        (abort_ev)
);

// File: tb/pp_fwd_tx_test.sv
module pp_fwd_tx_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic [7:0]  pd_out;
  logic        strobe_n;
  logic        busy_in = 1'b0;
  logic        err_in = 1'b0;
  logic        clr_err = 1'b0;
  logic        err_flag;
  logic        timeout_o;
  logic [7:0]  setup_cyc = 8'd1;
  logic [7:0]  strobe_cyc = 8'd1;
  logic [7:0]  hold_cyc = 8'd1;
  logic [15:0] timeout_cyc = 16'd50;

  int errs = 0;
  int checks = 0;

  always #10 clk = ~clk;

  pp_fwd_tx uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .pd_out(pd_out), .strobe_n(strobe_n),
    .busy_in(busy_in), .err_in(err_in), .clr_err(clr_err),
    .err_flag(err_flag), .timeout_o(timeout_o), .setup_cyc(setup_cyc),
    .strobe_cyc(strobe_cyc), .hold_cyc(hold_cyc), .timeout_cyc(timeout_cyc)
  );

  function automatic int len_of(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic drain;
    for (int i = 0; i < 2000 && !in_ready; i++) tick();
    busy_in = 1'b0;
  endtask

  // Full transfer with timing checks; in_valid is kept high with other data to show it is ignored.
  task automatic xfer(input logic [7:0] b, input int s, input int w, input int h,
                      input bit busy_mid);
    int k;
    int n;
    int m;
    setup_cyc = 8'(s); strobe_cyc = 8'(w); hold_cyc = 8'(h);
    in_data = b; in_valid = 1'b1;
    tick();
    in_data = ~b;
    chk(!in_ready, "R2", "ready after accept", int'(in_ready), 0);
    chk(pd_out == b, "R2", "data on lines", int'(pd_out), int'(b));
    k = 0;
    do begin
      tick(); k++;
    end while (strobe_n && k < 1000);
    chk(k == len_of(s) + 1, "R3", "edges to strobe fall", k, len_of(s) + 1);
    if (busy_mid) busy_in = 1'b1;
    n = 1;
    while (n < 1000) begin
      tick();
      if (strobe_n) break;
      n++;
    end
    chk(n == len_of(w), busy_mid ? "R10" : "R5", "strobe low cycles", n, len_of(w));
    m = 0;
    while (!in_ready && m < 1000) begin
      m++;
      if (pd_out != b) chk(1'b0, "R6", "data during hold", int'(pd_out), int'(b));
      tick();
    end
    chk(m == len_of(h), "R6", "hold cycles before ready", m, len_of(h));
    chk(pd_out == b, "R2", "data kept with other input offered", int'(pd_out), int'(b));
    in_valid = 1'b0;
    busy_in = 1'b0;
    tick();
  endtask

  task automatic t_reset;
    chk(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);
    chk(strobe_n == 1'b1, "R1", "strobe_n", int'(strobe_n), 1);
    chk(pd_out == 8'h00, "R1", "pd_out", int'(pd_out), 0);
    chk(err_flag == 1'b0, "R1", "err_flag", int'(err_flag), 0);
    chk(timeout_o == 1'b0, "R1", "timeout_o", int'(timeout_o), 0);
  endtask

  task automatic t_busy_gate;
    bit seen_low;
    setup_cyc = 8'd2; strobe_cyc = 8'd2; hold_cyc = 8'd1; timeout_cyc = 16'd100;
    busy_in = 1'b1;
    in_data = 8'h5A; in_valid = 1'b1;
    tick();
    in_valid = 1'b0;
    seen_low = 1'b0;
    for (int i = 0; i < 12; i++) begin
      tick();
      if (!strobe_n) seen_low = 1'b1;
    end
    chk(!seen_low, "R4", "strobe while busy", int'(seen_low), 0);
    busy_in = 1'b0;
    tick();
    chk(!strobe_n, "R4", "strobe one edge after busy clears", int'(strobe_n), 0);
    drain();
    tick();
  endtask

  task automatic t_timeout;
    bit early;
    setup_cyc = 8'd1; strobe_cyc = 8'd1; hold_cyc = 8'd1; timeout_cyc = 16'd5;
    busy_in = 1'b1;
    in_data = 8'hC3; in_valid = 1'b1;
    tick();
    in_valid = 1'b0;
    early = 1'b0;
    for (int i = 1; i < 6; i++) begin
      tick();
      if (!strobe_n || in_ready || timeout_o) early = 1'b1;
    end
    chk(!early, "R7", "no strobe, ready or flag before limit", int'(early), 0);
    tick();
    chk(in_ready, "R7", "ready back after timeout", int'(in_ready), 1);
    chk(timeout_o, "R7", "timeout pulse", int'(timeout_o), 1);
    tick();
    chk(!timeout_o, "R7", "timeout pulse length", int'(timeout_o), 0);
    chk(strobe_n, "R7", "no strobe after abort", int'(strobe_n), 1);
    busy_in = 1'b0;
    timeout_cyc = 16'd50;
  endtask

  task automatic t_error;
    bit seen_low;
    err_in = 1'b1;
    tick();
    err_in = 1'b0;
    chk(err_flag, "R8", "flag set by err_in", int'(err_flag), 1);
    tick(); tick();
    chk(err_flag, "R8", "flag sticky", int'(err_flag), 1);
    timeout_cyc = 16'd200; setup_cyc = 8'd1; strobe_cyc = 8'd1; hold_cyc = 8'd1;
    in_data = 8'h81; in_valid = 1'b1;
    tick();
    in_valid = 1'b0;
    seen_low = 1'b0;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (!strobe_n) seen_low = 1'b1;
    end
    chk(!seen_low, "R4", "strobe while error flag set", int'(seen_low), 0);
    clr_err = 1'b1;
    tick();
    clr_err = 1'b0;
    chk(!err_flag, "R8", "flag cleared", int'(err_flag), 0);
    tick();
    chk(!strobe_n, "R4", "strobe after flag cleared", int'(strobe_n), 0);
    drain();
    tick();
    timeout_cyc = 16'd50;
  endtask

  task automatic t_set_wins;
    err_in = 1'b1; clr_err = 1'b1;
    tick();
    chk(err_flag, "R9", "set wins over clear", int'(err_flag), 1);
    err_in = 1'b0;
    tick();
    clr_err = 1'b0;
    chk(!err_flag, "R8", "clear alone", int'(err_flag), 0);
  endtask

  initial begin
    #(20 * 200000);
    checks++; errs++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    xfer(8'hA5, 2, 3, 2, 1'b0);
    xfer(8'h3C, 0, 0, 0, 1'b0);
    xfer(8'hFF, 5, 1, 4, 1'b0);
    xfer(8'h01, 1, 4, 1, 1'b1);
    t_busy_gate();
    t_timeout();
    t_error();
    t_set_wins();
    xfer(8'h96, 3, 2, 3, 1'b0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule